// File: doc/BRIEF.md
# SPI Serial EEPROM Engine

This block is the protocol side of a byte-wide serial EEPROM seen by an SPI host in mode 0 or mode 3. A faster system clock oversamples the serial clock, chip select, serial input and a hold input. The block decodes a one-byte command and serves a 2048 x 8 array held in flip-flops. It runs sequential reads whose pointer wraps at the top of the array. Page writes are collected in a page buffer and committed when chip select rises on a byte boundary. A self-timed write cycle follows, reported on `busy`. Serial output data leaves on `so`, and `so_oe` tells the pad when to drive it.

The nonvolatile status bits and the protection policy live in a companion unit. That unit supplies the upper six status bits. It grants or refuses array commits for the page shown on `arr_wr_page`. It also grants or refuses status writes, and it receives accepted status writes as a one-cycle request with a data byte. The write-enable latch and the busy flag live here.

States of the controller: `S_IDLE` waits for chip select to fall (IDLE to OPCODE). `S_OPCODE` gathers eight command bits and then moves to `S_ADDR` (read or write), `S_SRRD` (status read), `S_SRWR` (status write), `S_LATCH` (set or clear write enable) or `S_IGNORE` (unknown command, or an array/status/latch command while busy). `S_ADDR` gathers sixteen address bits and moves to `S_RDATA` for a read or to `S_WDATA` for a write. `S_LATCH` and `S_SRWR` move to `S_IGNORE` on any clock bit beyond their frame. Chip select rising returns every state to `S_IDLE`.

Top module: `spi_eeprom_engine`

## Requirements
- R1: After reset, `so_oe`, `wel` and `busy` are 0 and the whole array reads as 0xFF.
- R2: Command 0x06 sets `wel` and 0x04 clears it, but only when chip select rises after exactly eight clock bits of that command; any extra clock bit in the same frame cancels it, so a write begun in the same frame does not happen.
- R3: Command 0x03 followed by a 16-bit address (upper five bits ignored) returns the byte at that address on `so`, most significant bit first, each bit changing after a falling SCK; further clocks return the following addresses.
- R4: A sequential read continues from address 0x7FF to 0x000.
- R5: Command 0x02 with address and data writes the bytes from that address; bytes past the end of the page land at the start of the same page.
- R6: The array is changed only when chip select rises right after the last bit of a data byte and `wel` is 1; a rise in the middle of a byte, or with `wel` at 0, leaves the array unchanged and starts no write cycle.
- R7: A commit raises `busy` for the write-cycle length; while busy, array read and write commands are ignored (`so_oe` stays 0) and status reads still work.
- R8: When a write cycle ends, `wel` is cleared.
- R9: Status read (0x05) returns bits 7..2 from `nv_status`, bit 1 `wel`, bit 0 `busy`, and repeats while clocked.
- R10: Status write (0x01) plus one data byte, with `wel` at 1 and `sr_wr_grant` high at the chip-select rise, gives one `sr_wr_req` pulse carrying the byte and starts a write cycle; with the grant low nothing happens.
- R11: An array commit needs `arr_wr_grant` high; `arr_wr_page` shows the base address of the page being written.
- R12: An unknown command leaves `so_oe` at 0 and changes neither `wel` nor the array.
- R13: While `hold_n` is low, SCK edges are ignored and `so_oe` is 0; the transfer resumes unchanged when `hold_n` returns high.
- R14: `so_oe` is 0 whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCK |
| rst_n | input | 1 | Active-low reset |
| sck | input | 1 | Serial clock |
| cs_n | input | 1 | Chip select, active low |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Pause input, active low |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Drive enable for `so` |
| nv_status | input | 6 | Status bits 7..2 from the companion unit |
| sr_wr_req | output | 1 | One-cycle status write request |
| sr_wr_data | output | 8 | Status byte sent with the request |
| sr_wr_grant | input | 1 | Companion allows status writes |
| arr_wr_page | output | ADDR_W | Base address of the page in the write buffer |
| arr_wr_grant | input | 1 | Companion allows writing that page |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Self-timed write cycle in progress |

## Verification
A wrong bit counter or state shows up within one frame: the first status or array byte comes out shifted or missing, or `so_oe` rises on a frame that should stay silent. A page pointer that leaves its page, or a commit taken at the wrong chip-select rise, cannot be seen until the following read, so every write is followed by a full read of the page. A latch or timer fault shows on `wel`, `busy` and the status byte a few system clocks after chip select rises.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam logic [7:0] CMD_SR_WRITE = 8'h01;
    localparam logic [7:0] CMD_WRITE    = 8'h02;
    localparam logic [7:0] CMD_READ     = 8'h03;
    localparam logic [7:0] CMD_WEN_CLR  = 8'h04;
    localparam logic [7:0] CMD_SR_READ  = 8'h05;
    localparam logic [7:0] CMD_WEN_SET  = 8'h06;

    typedef enum logic [3:0] {
        S_IDLE,
        S_OPCODE,
        S_ADDR,
        S_RDATA,
        S_WDATA,
        S_SRRD,
        S_SRWR,
        S_LATCH,
        S_IGNORE
    } eep_state_e;
endpackage

// File: rtl/eep_sync.sv
module eep_sync #(
    parameter int N = 4,
    parameter logic [N-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST[g];
                stab_q <= RST[g];
            end else begin
                meta_q <= d[g];
                stab_q <= meta_q;
            end
        end
        assign q[g] = stab_q;
    end
endmodule

// File: rtl/eep_wtimer.sv
module eep_wtimer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (start && !busy_q) begin
            cnt_q  <= LAST;
            busy_q <= 1'b1;
        end else if (busy_q) begin
            if (cnt_q == '0) busy_q <= 1'b0;
            else             cnt_q  <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);
endmodule

// File: rtl/eep_pagebuf.sv
module eep_pagebuf #(
    parameter int PAGE = 16,
    localparam int PB = $clog2(PAGE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [PB-1:0]     wr_idx,
    input  logic [7:0]        wr_byte,
    output logic [PAGE*8-1:0] data,
    output logic [PAGE-1:0]   mask
);
    for (genvar g = 0; g < PAGE; g++) begin : g_slot
        logic [7:0] byte_q;
        logic       vld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else if (clr) begin
                vld_q  <= 1'b0;
            end else if (wr_en && wr_idx == PB'(g)) begin
                byte_q <= wr_byte;
                vld_q  <= 1'b1;
            end
        end
        assign data[g*8 +: 8] = byte_q;
        assign mask[g]        = vld_q;
    end
endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 11,
    parameter int PAGE = 16,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata,
    input  logic              commit,
    input  logic [ADDR_W-1:0] page_base,
    input  logic [PAGE*8-1:0] pdata,
    input  logic [PAGE-1:0]   pmask
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (commit) begin
            for (int i = 0; i < PAGE; i++) begin
                if (pmask[i]) mem[page_base | ADDR_W'(i)] <= pdata[i*8 +: 8];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine
    import eep_pkg::*;
#(
    parameter int ADDR_W  = 11,
    parameter int PAGE    = 16,
    parameter int WCYCLES = 200000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              si,
    input  logic              hold_n,
    output logic              so,
    output logic              so_oe,
    input  logic [5:0]        nv_status,
    output logic              sr_wr_req,
    output logic [7:0]        sr_wr_data,
    input  logic              sr_wr_grant,
    output logic [ADDR_W-1:0] arr_wr_page,
    input  logic              arr_wr_grant,
    output logic              wel,
    output logic              busy
);
    localparam int PB = $clog2(PAGE);
    localparam int SHW = ADDR_W - 1;

    // input synchronisation and edge detection
    logic [3:0] sync_q;
    logic       sck_s, cs_s, si_s, hold_s;
    logic       sck_d, cs_d;

    eep_sync #(.N(4), .RST(4'b0101)) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d   ({sck, cs_n, si, hold_n}),
        .q   (sync_q)
    );
    assign {sck_s, cs_s, si_s, hold_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_d <= sck_s;
            cs_d  <= cs_s;
        end
    end

    logic cs_low, cs_rise, cs_fall, link_on, sck_rise, sck_fall;
    assign cs_low   = ~cs_s;
    assign cs_rise  = cs_s & ~cs_d;
    assign cs_fall  = ~cs_s & cs_d;
    assign link_on  = cs_low & hold_s;
    assign sck_rise = sck_s & ~sck_d & link_on;
    assign sck_fall = ~sck_s & sck_d & link_on;

    // state and datapath registers
    eep_state_e        state_q, state_d;
    logic [SHW-1:0]    sh_q;
    logic [3:0]        bit_q;
    logic              is_rd_q;
    logic              latch_set_q;
    logic              aligned_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [7:0]        out_byte_q;
    logic [2:0]        oidx_q;
    logic              so_q;
    logic              out_on_q;
    logic              wel_q;
    logic [7:0]        sr_data_q;

    logic [7:0]        in_byte;
    logic [ADDR_W-1:0] addr_in;
    logic [7:0]        status_byte;
    logic [7:0]        arr_rdata;
    logic [ADDR_W-1:0] arr_raddr;
    logic              commit_arr;
    logic              timer_busy, timer_done;
    logic              buf_clr, buf_wr;
    logic [PAGE*8-1:0] buf_data;
    logic [PAGE-1:0]   buf_mask;

    assign in_byte     = {sh_q[6:0], si_s};
    assign addr_in     = {sh_q[ADDR_W-2:0], si_s};
    assign status_byte = {nv_status, wel_q, timer_busy};
    assign arr_raddr   = (state_q == S_ADDR) ? addr_in : ptr_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (cs_fall) state_d = S_OPCODE;
            S_OPCODE: begin
                if (sck_rise && bit_q == 4'd7) begin
                    unique case (in_byte)
                        CMD_READ, CMD_WRITE:
                            state_d = timer_busy ? S_IGNORE : S_ADDR;
                        CMD_SR_WRITE:
                            state_d = timer_busy ? S_IGNORE : S_SRWR;
                        CMD_WEN_SET, CMD_WEN_CLR:
                            state_d = timer_busy ? S_IGNORE : S_LATCH;
                        CMD_SR_READ:
                            state_d = S_SRRD;
                        default:
                            state_d = S_IGNORE;
                    endcase
                end
            end
            S_ADDR: if (sck_rise && bit_q == 4'd15) state_d = is_rd_q ? S_RDATA : S_WDATA;
            S_LATCH: if (sck_rise) state_d = S_IGNORE;
            S_SRWR: if (sck_rise && aligned_q) state_d = S_IGNORE;
            S_RDATA, S_WDATA, S_SRRD, S_IGNORE: state_d = state_q;
            default: state_d = S_IDLE;
        endcase
        if (cs_rise) state_d = S_IDLE;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q        <= '0;
            bit_q       <= '0;
            is_rd_q     <= 1'b0;
            latch_set_q <= 1'b0;
            aligned_q   <= 1'b0;
            ptr_q       <= '0;
            out_byte_q  <= '0;
            oidx_q      <= 3'd7;
            so_q        <= 1'b0;
            out_on_q    <= 1'b0;
            sr_data_q   <= '0;
        end else if (cs_rise || cs_fall) begin
            bit_q     <= '0;
            out_on_q  <= 1'b0;
            aligned_q <= 1'b0;
        end else if (sck_rise) begin
            sh_q <= {sh_q[SHW-2:0], si_s};
            unique case (state_q)
                S_OPCODE: begin
                    if (bit_q == 4'd7) begin
                        bit_q       <= '0;
                        is_rd_q     <= (in_byte == CMD_READ);
                        latch_set_q <= (in_byte == CMD_WEN_SET);
                        out_byte_q  <= status_byte;
                        oidx_q      <= 3'd7;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                S_ADDR: begin
                    if (bit_q == 4'd15) begin
                        bit_q      <= '0;
                        aligned_q  <= 1'b0;
                        out_byte_q <= arr_rdata;
                        oidx_q     <= 3'd7;
                        ptr_q      <= is_rd_q ? addr_in + 1'b1 : addr_in;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                    end
                end
                S_WDATA: begin
                    if (bit_q == 4'd7) begin
                        bit_q     <= '0;
                        aligned_q <= 1'b1;
                        ptr_q     <= {ptr_q[ADDR_W-1:PB], ptr_q[PB-1:0] + 1'b1};
                    end else begin
                        bit_q     <= bit_q + 1'b1;
                        aligned_q <= 1'b0;
                    end
                end
                S_SRWR: begin
                    if (bit_q == 4'd7) begin
                        aligned_q <= 1'b1;
                        sr_data_q <= in_byte;
                    end
                    bit_q <= bit_q + 1'b1;
                end
                default: ;
            endcase
        end else if (sck_fall && (state_q == S_RDATA || state_q == S_SRRD)) begin
            so_q     <= out_byte_q[oidx_q];
            out_on_q <= 1'b1;
            if (oidx_q == 3'd0) begin
                oidx_q <= 3'd7;
                if (state_q == S_RDATA) begin
                    out_byte_q <= arr_rdata;
                    ptr_q      <= ptr_q + 1'b1;
                end else begin
                    out_byte_q <= status_byte;
                end
            end else begin
                oidx_q <= oidx_q - 1'b1;
            end
        end
    end

    // write-enable latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                               wel_q <= 1'b0;
        else if (timer_done)                      wel_q <= 1'b0;
        else if (cs_rise && state_q == S_LATCH)   wel_q <= latch_set_q;
    end

    // outputs
    always_comb begin
        buf_clr    = sck_rise && state_q == S_ADDR && bit_q == 4'd15;
        buf_wr     = sck_rise && state_q == S_WDATA && bit_q == 4'd7;
        commit_arr = cs_rise && state_q == S_WDATA && aligned_q && wel_q
                     && arr_wr_grant && !timer_busy;
        sr_wr_req  = cs_rise && state_q == S_SRWR && aligned_q && wel_q
                     && sr_wr_grant && !timer_busy;
        so_oe      = out_on_q && link_on && (state_q == S_RDATA || state_q == S_SRRD);
        so         = so_q;
        sr_wr_data = sr_data_q;
        arr_wr_page = {ptr_q[ADDR_W-1:PB], {PB{1'b0}}};
        wel        = wel_q;
        busy       = timer_busy;
    end

    eep_pagebuf #(.PAGE(PAGE)) u_pagebuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (buf_clr),
        .wr_en   (buf_wr),
        .wr_idx  (ptr_q[PB-1:0]),
        .wr_byte (in_byte),
        .data    (buf_data),
        .mask    (buf_mask)
    );

    eep_array #(.ADDR_W(ADDR_W), .PAGE(PAGE)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .raddr     (arr_raddr),
        .rdata     (arr_rdata),
        .commit    (commit_arr),
        .page_base (arr_wr_page),
        .pdata     (buf_data),
        .pmask     (buf_mask)
    );

    eep_wtimer #(.CYCLES(WCYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (commit_arr | sr_wr_req),
        .busy  (timer_busy),
        .done  (timer_done)
    );
endmodule

// File: rtl/eep_engine_chk.sv
module eep_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_low,
    input logic cs_rise,
    input logic hold_ok,
    input logic so_oe,
    input logic busy,
    input logic wel,
    input logic commit,
    input logic sr_wr_req,
    input logic sr_wr_grant
);
    AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n) !cs_low |-> !so_oe); // R14
    AST_OE_OFF_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !hold_ok |-> !so_oe); // R13
    AST_BUSY_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(cs_rise)); // R7
    AST_NO_COMMIT_BUSY: assert property (@(posedge clk) disable iff (!rst_n) commit |-> !busy); // R7
    AST_WEL_OFF_AT_END: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> !wel); // R8
    AST_WEL_SET_AT_CS: assert property (@(posedge clk) disable iff (!rst_n) $rose(wel) |-> $past(cs_rise)); // R2
    AST_SR_REQ_GATED: assert property (@(posedge clk) disable iff (!rst_n) sr_wr_req |-> (sr_wr_grant && wel)); // R10
    AST_SR_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n) sr_wr_req |=> !sr_wr_req); // R10
endmodule

bind spi_eeprom_engine eep_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_low      (cs_low),
    .cs_rise     (cs_rise),
    .hold_ok     (hold_s),
    .so_oe       (so_oe),
    .busy        (busy),
    .wel         (wel),
    .commit      (commit_arr),
    .sr_wr_req   (sr_wr_req),
    .sr_wr_grant (sr_wr_grant)
);

// File: tb/tb_spi_eeprom_engine.sv
module tb_spi_eeprom_engine;
    localparam int PAGE = 16;
    localparam int WCYC = 1500;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
    logic so, so_oe, sr_wr_req, sr_wr_grant = 1'b1, arr_wr_grant = 1'b1, wel, busy;
    logic [5:0]  nv_status = 6'b101010;
    logic [7:0]  sr_wr_data;
    logic [10:0] arr_wr_page;

    always #2.5 clk = ~clk;

    spi_eeprom_engine #(.ADDR_W(11), .PAGE(PAGE), .WCYCLES(WCYC)) dut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .si(si), .hold_n(hold_n),
        .so(so), .so_oe(so_oe), .nv_status(nv_status),
        .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data), .sr_wr_grant(sr_wr_grant),
        .arr_wr_page(arr_wr_page), .arr_wr_grant(arr_wr_grant), .wel(wel), .busy(busy)
    );

    typedef struct { logic [7:0] v; string tag; } exp_t;
    exp_t exp_q[$];
    int n_cmp = 0, n_bad = 0;
    logic [7:0] model [2048];
    logic [7:0] wbuf [16];
    logic oe_seen = 1'b0;
    int sr_cnt = 0;
    logic [7:0] sr_last = '0;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // monitor: assemble SO bytes and compare against the expected queue
    logic [7:0] mon_sh = '0;
    int mon_cnt = 0;
    always @(posedge sck or posedge cs_n) begin
        if (cs_n) begin
            mon_cnt = 0;
        end else if (so_oe) begin
            oe_seen = 1'b1;
            mon_sh = {mon_sh[6:0], so};
            mon_cnt++;
            if (mon_cnt == 8) begin
                mon_cnt = 0;
                if (exp_q.size() == 0) begin
                    chk(0, "R14", "unexpected SO byte", mon_sh, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(mon_sh == e.v, e.tag, "SO byte", mon_sh, e.v);
                end
            end
        end
    end

    always @(posedge clk) if (sr_wr_req) begin
        sr_cnt++;
        sr_last <= sr_wr_data;
    end

    task automatic bitx(input logic b);
        @(negedge clk); si = b;
        repeat (HALF) @(negedge clk); sck = 1'b1;
        repeat (HALF) @(negedge clk); sck = 1'b0;
    endtask
    task automatic xbyte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bitx(b[i]);
    endtask
    task automatic xaddr(input logic [10:0] a);
        xbyte({5'b10110, a[10:8]});
        xbyte(a[7:0]);
    endtask
    task automatic cs_lo();
        @(negedge clk); cs_n = 1'b0; oe_seen = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask
    task automatic cs_hi();
        repeat (HALF) @(negedge clk); cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask
    task automatic drained(input string tag);
        chk(exp_q.size() == 0, tag, "missing SO bytes", exp_q.size(), 0);
        exp_q.delete();
    endtask
    task automatic cmd1(input logic [7:0] c);
        cs_lo(); xbyte(c); cs_hi();
    endtask
    task automatic rdsr(input logic [7:0] expv, input int n, input string tag);
        cs_lo(); xbyte(8'h05);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back('{expv, tag});
            xbyte(8'h00);
        end
        cs_hi(); drained(tag);
    endtask
    task automatic rd(input logic [10:0] a, input int n, input string tag);
        cs_lo(); xbyte(8'h03); xaddr(a);
        for (int i = 0; i < n; i++) exp_q.push_back('{model[(int'(a) + i) % 2048], tag});
        for (int i = 0; i < n; i++) xbyte(8'h00);
        cs_hi(); drained(tag);
    endtask
    task automatic wr(input logic [10:0] a, input int n, input bit expect_commit);
        cs_lo(); xbyte(8'h02); xaddr(a);
        for (int i = 0; i < n; i++) xbyte(wbuf[i]);
        cs_hi();
        if (expect_commit)
            for (int i = 0; i < n; i++)
                model[(int'(a) & ~(PAGE - 1)) | ((int'(a) + i) % PAGE)] = wbuf[i];
    endtask
    task automatic wait_idle();
        for (int i = 0; i < 3 * WCYC && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 2048; i++) model[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R1: reset state
        chk(so_oe == 0, "R1", "so_oe", so_oe, 0);
        chk(wel == 0, "R1", "wel", wel, 0);
        chk(busy == 0, "R1", "busy", busy, 0);
        rd(11'h123, 2, "R1");
        // R9: status format, repeated
        rdsr(8'hA8, 2, "R9");
        // R2: set and clear the latch
        cmd1(8'h06);
        chk(wel == 1, "R2", "wel after set", wel, 1);
        rdsr(8'hAA, 1, "R2");
        cmd1(8'h04);
        chk(wel == 0, "R2", "wel after clear", wel, 0);
        cs_lo(); xbyte(8'h06); bitx(1'b0); cs_hi();
        chk(wel == 0, "R2", "wel after long frame", wel, 0);
        cs_lo(); xbyte(8'h06); xbyte(8'h02); xaddr(11'h040); xbyte(8'h55); cs_hi();
        chk(wel == 0, "R2", "wel same-frame write", wel, 0);
        chk(busy == 0, "R2", "busy same-frame write", busy, 0);
        // R6: write without latch
        wbuf[0] = 8'h5A;
        wr(11'h050, 1, 0);
        chk(busy == 0, "R6", "busy without wel", busy, 0);
        rd(11'h040, 1, "R2");
        rd(11'h050, 1, "R6");
        // R5/R7/R11: page write with wrap
        cmd1(8'h06);
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        wr(11'h01E, 4, 1);
        chk(busy == 1, "R7", "busy after commit", busy, 1);
        chk(arr_wr_page == 11'h010, "R11", "page base", arr_wr_page, 11'h010);
        rdsr(8'hAB, 1, "R7");
        cs_lo(); xbyte(8'h03); xaddr(11'h010); xbyte(8'h00); cs_hi();
        chk(oe_seen == 0, "R7", "read while busy drove SO", oe_seen, 0);
        wait_idle();
        chk(busy == 0, "R7", "busy at end", busy, 0);
        chk(wel == 0, "R8", "wel after cycle", wel, 0);
        rd(11'h010, 16, "R5");
        // R3: sequential read crossing a page
        rd(11'h01D, 4, "R3");
        // R6: chip select rises mid-byte
        cmd1(8'h06);
        cs_lo(); xbyte(8'h02); xaddr(11'h020); xbyte(8'hC3);
        for (int i = 0; i < 4; i++) bitx(1'b1);
        cs_hi();
        chk(busy == 0, "R6", "busy after mid-byte rise", busy, 0);
        rd(11'h020, 1, "R6");
        // R11: refused array grant
        arr_wr_grant = 1'b0;
        wbuf[0] = 8'h77;
        wr(11'h030, 1, 0);
        chk(busy == 0, "R11", "busy with grant low", busy, 0);
        arr_wr_grant = 1'b1;
        rd(11'h030, 1, "R11");
        // R4: rollover
        wbuf[0] = 8'hAB; wbuf[1] = 8'hCD;
        wr(11'h7FE, 2, 1);
        wait_idle();
        cmd1(8'h06);
        wbuf[0] = 8'h01; wbuf[1] = 8'h02;
        wr(11'h000, 2, 1);
        wait_idle();
        rd(11'h7FE, 4, "R4");
        // R10: status write granted and refused
        cmd1(8'h06);
        cs_lo(); xbyte(8'h01); xbyte(8'h8C); cs_hi();
        chk(sr_cnt == 1, "R10", "request count", sr_cnt, 1);
        chk(sr_last == 8'h8C, "R10", "request data", sr_last, 8'h8C);
        chk(busy == 1, "R10", "busy after status write", busy, 1);
        wait_idle();
        chk(wel == 0, "R8", "wel after status write", wel, 0);
        cmd1(8'h06);
        sr_wr_grant = 1'b0;
        cs_lo(); xbyte(8'h01); xbyte(8'h44); cs_hi();
        chk(sr_cnt == 1, "R10", "request with grant low", sr_cnt, 1);
        chk(busy == 0, "R10", "busy with grant low", busy, 0);
        sr_wr_grant = 1'b1;
        // R12: unknown command
        cs_lo(); xbyte(8'h9F); xbyte(8'h00); xbyte(8'h00); cs_hi();
        chk(oe_seen == 0, "R12", "SO driven on unknown", oe_seen, 0);
        chk(wel == 1, "R12", "wel after unknown", wel, 1);
        cmd1(8'h04);
        // R13: hold in the middle of a read
        cs_lo(); xbyte(8'h03); xaddr(11'h010);
        exp_q.push_back('{model[11'h010], "R13"});
        exp_q.push_back('{model[11'h011], "R13"});
        for (int i = 0; i < 4; i++) bitx(1'b0);
        @(negedge clk); hold_n = 1'b0;
        repeat (HALF) @(negedge clk);
        chk(so_oe == 0, "R13", "so_oe during hold", so_oe, 0);
        for (int i = 0; i < 5; i++) bitx(1'b1);
        repeat (HALF) @(negedge clk); hold_n = 1'b1;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < 12; i++) bitx(1'b0);
        cs_hi(); drained("R13");
        // R14: chip select high
        chk(so_oe == 0, "R14", "so_oe with cs high", so_oe, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule